// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block sorts every bus access by its 24-bit address into one of seven destinations: one of four programmable external areas, the built-in I/O window, the built-in memory window, or a catch-all external space. Each external area owns an active-low select line. Software programs each area with three registers: a base value for the top eight address bits, a mask that removes address bits from the compare, and an enable bit. Ordinary bus cycles need no extra cycle to decode. The decode path is purely combinational from `bus_addr` and `bus_valid` to the outputs.

The two built-in windows are fixed by parameters. Each is a power-of-two block on its own alignment. They take precedence over every programmable area. When several candidates match one address, a fixed order decides the winner: I/O, then memory, then areas 0, 1, 2 and 3, then the catch-all space. Areas 0 and 1 give fine granularity, down to 256 bytes. Areas 2 and 3 cover coarser 32 KiB steps.

Top module: `csdec`

## Requirements
- R1: After reset all areas are disabled, so a valid access outside the built-in windows gives `cs_n`=4'b1111, `ext_dflt`=1 and `dest`=6.
- R2: An enabled area compares the selected address bits against {base[7:0], 16'h0000}. A write with `cfg_kind`=0 sets the base and takes effect on the cycle after the write edge.
- R3: In the mask register (`cfg_kind`=1), a bit at 0 keeps its address bits in the compare and a bit at 1 drops them. For areas 0 and 1, mask[7:2] map to A21..A16, mask[1] maps to the group A15..A9, and mask[0] maps to A8.
- R4: For areas 0 and 1, A23 and A22 are compared whatever the mask holds.
- R5: For areas 2 and 3, A23 is always compared, mask[7:0] map to A22..A15, and A14..A0 are never compared.
- R6: A7..A0 never take part in any area compare.
- R7: With base 8'h11 and mask 8'h01, area 1 selects exactly 0x110000 through 0x1101FF.
- R8: A selected area drives its own `cs_n` bit low and reports its number (0..3) on `dest`. Among overlapping areas, the lowest number wins.
- R9: Accesses inside the I/O window (default 0x000000–0x0000FF) give `dest`=4. Accesses inside the memory window (default 0x000000–0x003FFF) that miss the I/O window give `dest`=5. In both cases all selects stay high and `ext_dflt`=0, and I/O wins over memory.
- R10: When `bus_valid`=0, `cs_n`=4'b1111, `ext_dflt`=0 and `dest`=7.
- R11: No more than one `cs_n` bit is low at any time.
- R12: Bit 0 of a `cfg_kind`=2 write sets the area's enable. A disabled area never selects. Writes with `cfg_kind`=3 change nothing.
- R13: A valid access that hits no built-in window and no enabled area gives `ext_dflt`=1 and `dest`=6, with all selects high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 24 | Address of the current access |
| bus_valid | input | 1 | Access strobe; the outputs are idle when low |
| cfg_we | input | 1 | Configuration write enable |
| cfg_area | input | 2 | Area addressed by the write |
| cfg_kind | input | 2 | 0 base, 1 mask, 2 control, 3 unused |
| cfg_wdata | input | 8 | Write data |
| cs_n | output | 4 | Active-low selects, one per area |
| ext_dflt | output | 1 | Access falls into the catch-all external space |
| dest | output | 3 | 0..3 area, 4 I/O, 5 memory, 6 catch-all, 7 idle |

## Verification
The bench probes both edges of the 512-byte example window. A decoder that compared A8 would lose the upper half of that window, and one that ignored A9 would select 0x110200. It sets a fully masked area 0 against addresses with the top two bits changed, which shows whether A23/A22 really bypass the mask. It also checks that area 2 ignores the low fifteen bits: 0x827FFF must match and 0x828000 must not. The remaining tests stack areas on top of each other and on top of the built-in windows. A reversed priority chain would then pull the wrong select low or let an external select fire on a built-in hit, and an unused-kind write must leave the area's enable intact.

// File: rtl/csdec.sv
module csdec #(
  parameter logic [23:0] IO_BASE  = 24'h000000,
  parameter int          IO_BITS  = 8,
  parameter logic [23:0] MEM_BASE = 24'h000000,
  parameter int          MEM_BITS = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] bus_addr,
  input  logic        bus_valid,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_area,
  input  logic [1:0]  cfg_kind,
  input  logic [7:0]  cfg_wdata,
  output logic [3:0]  cs_n,
  output logic        ext_dflt,
  output logic [2:0]  dest
);
  localparam int NA = 4;

  logic [7:0]    base_q [NA];
  logic [7:0]    mask_q [NA];
  logic [NA-1:0] en_q;
  logic [NA-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NA; i++) begin
        base_q[i] <= 8'h00;
        mask_q[i] <= 8'h00;
      end
      en_q <= '0;
    end else if (cfg_we) begin
      case (cfg_kind)
        2'd0:    base_q[cfg_area] <= cfg_wdata;
        2'd1:    mask_q[cfg_area] <= cfg_wdata;
        2'd2:    en_q[cfg_area]   <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NA; g++) begin : g_area
    logic [23:0] care;
    if (g < 2) begin : g_fine
      assign care = {2'b11, ~mask_q[g][7:2], {7{~mask_q[g][1]}}, ~mask_q[g][0], 8'h00};
    end else begin : g_coarse
      assign care = {1'b1, ~mask_q[g], 15'h0000};
    end
    assign hit[g] = en_q[g] && (((bus_addr ^ {base_q[g], 16'h0000}) & care) == 24'h000000);
  end

  logic in_io, in_mem;
  assign in_io  = (bus_addr >> IO_BITS)  == (IO_BASE >> IO_BITS);
  assign in_mem = (bus_addr >> MEM_BITS) == (MEM_BASE >> MEM_BITS);

  always_comb begin
    logic [1:0] pick;
    logic       any;
    pick = 2'd0;
    any  = 1'b0;
    for (int i = NA - 1; i >= 0; i--) begin
      if (hit[i]) begin
        pick = 2'(i);
        any  = 1'b1;
      end
    end
    cs_n     = '1;
    ext_dflt = 1'b0;
    dest     = 3'd7;
    if (bus_valid) begin
      if (in_io)
        dest = 3'd4;
      else if (in_mem)
        dest = 3'd5;
      else if (any) begin
        dest       = {1'b0, pick};
        cs_n[pick] = 1'b0;
      end else begin
        ext_dflt = 1'b1;
        dest     = 3'd6;
      end
    end
  end

  p_single_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (cs_n == 4'hF && !ext_dflt && dest == 3'd7));
  p_builtin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (in_io || in_mem)) |-> (cs_n == 4'hF && !ext_dflt));
  p_dflt_r13: assert property (@(posedge clk) disable iff (!rst_n)
    ext_dflt |-> (cs_n == 4'hF && dest == 3'd6 && hit == '0));
  p_cs_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != 4'hF) |-> (!dest[2] && !cs_n[dest[1:0]] && hit[dest[1:0]]));
  p_enable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_kind == 2'd2) |=> (en_q[$past(cfg_area)] == $past(cfg_wdata[0])));
endmodule

// File: tb/csdec_test.sv
module csdec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        bus_valid = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_area = '0;
  logic [1:0]  cfg_kind = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [3:0]  cs_n;
  logic        ext_dflt;
  logic [2:0]  dest;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  csdec uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_valid(bus_valid),
    .cfg_we(cfg_we), .cfg_area(cfg_area), .cfg_kind(cfg_kind), .cfg_wdata(cfg_wdata),
    .cs_n(cs_n), .ext_dflt(ext_dflt), .dest(dest));

  task automatic wr(input logic [1:0] a, input logic [1:0] k, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_area = a; cfg_kind = k; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic probe(input logic [23:0] a, input logic v, input logic [3:0] ecs,
                       input logic edf, input logic [2:0] ed, input string req);
    @(negedge clk);
    bus_addr = a; bus_valid = v;
    #1;
    checks++;
    if (cs_n !== ecs || ext_dflt !== edf || dest !== ed) begin
      errors++;
      $display("FAIL %s addr=%h actual cs_n=%b dflt=%b dest=%0d expected cs_n=%b dflt=%b dest=%0d",
               req, a, cs_n, ext_dflt, dest, ecs, edf, ed);
    end
  endtask

  task automatic t_reset;
    probe(24'h110000, 1'b1, 4'hF, 1'b1, 3'd6, "R1");
    probe(24'h123456, 1'b0, 4'hF, 1'b0, 3'd7, "R10");
  endtask

  task automatic t_fine_window;
    wr(2'd1, 2'd0, 8'h11);
    wr(2'd1, 2'd1, 8'h01);
    probe(24'h110000, 1'b1, 4'hF, 1'b1, 3'd6, "R12 still disabled");
    wr(2'd1, 2'd2, 8'h01);
    probe(24'h110000, 1'b1, 4'b1101, 1'b0, 3'd1, "R7 low edge");
    probe(24'h1101FF, 1'b1, 4'b1101, 1'b0, 3'd1, "R7 high edge");
    probe(24'h1100AB, 1'b1, 4'b1101, 1'b0, 3'd1, "R6");
    probe(24'h110200, 1'b1, 4'hF, 1'b1, 3'd6, "R3 A9 compared");
    probe(24'h10FFFF, 1'b1, 4'hF, 1'b1, 3'd6, "R13");
    probe(24'h310000, 1'b1, 4'hF, 1'b1, 3'd6, "R2 A21 compared");
  endtask

  task automatic t_top_bits;
    wr(2'd0, 2'd0, 8'h40);
    wr(2'd0, 2'd1, 8'hFF);
    wr(2'd0, 2'd2, 8'h01);
    probe(24'h7ABCDE, 1'b1, 4'b1110, 1'b0, 3'd0, "R4 inside");
    probe(24'hC00000, 1'b1, 4'hF, 1'b1, 3'd6, "R4 A23 differs");
    probe(24'h3ABCDE, 1'b1, 4'hF, 1'b1, 3'd6, "R4 A22 differs");
  endtask

  task automatic t_coarse;
    wr(2'd2, 2'd0, 8'h82);
    wr(2'd2, 2'd2, 8'h01);
    probe(24'h827FFF, 1'b1, 4'b1011, 1'b0, 3'd2, "R5 low bits ignored");
    probe(24'h828000, 1'b1, 4'hF, 1'b1, 3'd6, "R5 A15 compared");
    wr(2'd2, 2'd0, 8'h80);
    wr(2'd2, 2'd1, 8'hFF);
    probe(24'hF234AB, 1'b1, 4'b1011, 1'b0, 3'd2, "R5 masked");
    probe(24'h7234AB, 1'b1, 4'b1110, 1'b0, 3'd0, "R5 A23 compared");
  endtask

  task automatic t_priority;
    wr(2'd3, 2'd0, 8'h80);
    wr(2'd3, 2'd2, 8'h01);
    probe(24'h800100, 1'b1, 4'b1011, 1'b0, 3'd2, "R8 area2 over area3");
    wr(2'd2, 2'd2, 8'h00);
    probe(24'h800100, 1'b1, 4'b0111, 1'b0, 3'd3, "R8 area3 alone");
    probe(24'h808000, 1'b1, 4'hF, 1'b1, 3'd6, "R13 past area3");
    wr(2'd0, 2'd0, 8'h11);
    probe(24'h110000, 1'b1, 4'b1110, 1'b0, 3'd0, "R8 area0 over area1");
    probe(24'h000010, 1'b1, 4'hF, 1'b0, 3'd4, "R9 io");
    probe(24'h002000, 1'b1, 4'hF, 1'b0, 3'd5, "R9 mem");
    wr(2'd0, 2'd2, 8'h00);
    wr(2'd1, 2'd3, 8'h00);
    probe(24'h110123, 1'b1, 4'b1101, 1'b0, 3'd1, "R12 kind 3 ignored");
    probe(24'h110123, 1'b0, 4'hF, 1'b0, 3'd7, "R10 idle");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fine_window();
    t_top_bits();
    t_coarse();
    t_priority();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule